// File: doc/BRIEF.md
# Mains-Locked Four-Step Motor Speed Controller

This block switches a single-winding motor on and off in whole mains half-cycles. A pulse on the zero-crossing input marks the start of each half-cycle. At every such pulse the block decides whether the coming half-cycle is powered. The decision comes from a two-bit speed switch and from a four-slot rotation. Because the drive can only turn on at a zero crossing, power is never applied part-way through a half-cycle.

Two protections sit between the schedule and the output pin. A sampled motor-current word that stays above its limit for eight half-cycles in a row indicates a stall. A temperature estimate above its limit indicates overheating. Either condition forces the drive off at once and latches a fault. The fault stays set until the speed switch is moved back to its lowest position or the block is reset. Three indicator outputs show power, overload and over-temperature.

Top module: `mixer_drive_ctrl`

## Requirements
- R1: With speed switch value n (0..3), the half-cycles after reset are numbered from 0 in a repeating 0,1,2,3 rotation. Half-cycle k is driven exactly when (k mod 4) <= n, so n+1 of every 4 half-cycles are powered.
- R2: `drive_out` changes from 0 to 1 only on the clock edge that samples `zc_strobe` high. It reads 0 from reset until the first strobe.
- R3: A stall is detected when `cur_level` is strictly greater than `cur_limit` at 8 consecutive strobes. A strobe with `cur_level` <= `cur_limit` restarts the count.
- R4: On the edge where a stall is detected, `drive_out` goes to 0 and `led_overload` goes to 1.
- R5: When `temp_level` is strictly greater than `temp_limit` on a clock edge, `drive_out` is 0 and `led_thermal` is 1 after that edge. This holds even in the middle of a half-cycle. Equality is not a fault.
- R6: A change of `speed_sel` has no effect on `drive_out` until the next strobe.
- R7: Fault indicators latch. They keep the drive at 0 across later strobes, even after the causing condition goes away. They clear on the edge after `speed_sel` changes from a nonzero value to 0, or on reset; a fault condition present on that same edge wins. Once a fault is cleared, the drive stays off until the next strobe.
- R8: `led_power` is 0 while `rst` is high and 1 from the first clock edge that sees `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_strobe | input | 1 | One-cycle pulse at each mains zero crossing |
| speed_sel | input | 2 | Speed switch position, 0 slowest to 3 fastest |
| cur_level | input | CUR_W | Sampled motor current word |
| cur_limit | input | CUR_W | Current threshold used for stall detection |
| temp_level | input | TEMP_W | Winding temperature estimate |
| temp_limit | input | TEMP_W | Temperature threshold |
| drive_out | output | 1 | Motor drive enable, held for whole half-cycles |
| led_power | output | 1 | Power-on indicator |
| led_overload | output | 1 | Stall fault indicator |
| led_thermal | output | 1 | Over-temperature indicator |

## Verification
A slot counter that has drifted shows up as a wrong powered/unpowered pattern over the next four strobes. The pattern is visible the cycle after each strobe. A stall counter that fails to restart, or one that counts off by one, moves the overload flag by one strobe relative to the eighth over-limit sample. Latch-clear faults appear one clock after the switch reaches position 0. An early or late drive transition shows directly as a drive change on a cycle with no strobe.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    localparam int SLOT_COUNT = 4;
    localparam int SLOT_W     = $clog2(SLOT_COUNT);

    typedef logic [1:0]        speed_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic stall;
        logic thermal;
    } fault_t;

    function automatic logic slot_powered(input slot_t slot, input speed_t spd);
        return slot <= slot_t'(spd);
    endfunction

    function automatic logic any_fault(input fault_t f);
        return f.stall | f.thermal;
    endfunction

endpackage

// File: rtl/mdc_phase_sched.sv
module mdc_phase_sched
    import mdc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   zc_strobe,
    input  speed_t speed_sel,
    output logic   next_on
);
    slot_t slot_q;
    slot_t slot_n;

    assign slot_n  = slot_q + slot_t'(1);
    assign next_on = slot_powered(slot_n, speed_sel);

    always_ff @(posedge clk) begin
        if (rst)            slot_q <= slot_t'(SLOT_COUNT - 1);
        else if (zc_strobe) slot_q <= slot_n;
    end

    assert_slot_steady_R1: assert property (@(posedge clk) disable iff (rst)
        !zc_strobe |=> $stable(slot_q));
endmodule

// File: rtl/mdc_stall_mon.sv
module mdc_stall_mon #(
    parameter int CUR_W    = 10,
    parameter int STALL_HC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zc_strobe,
    input  logic             clr,
    input  logic [CUR_W-1:0] cur_level,
    input  logic [CUR_W-1:0] cur_limit,
    output logic             stall_next,
    output logic             stall_q
);
    localparam int CNT_W = $clog2(STALL_HC + 1);

    logic [CNT_W-1:0] run_q;
    logic             over;
    logic             hit;

    assign over       = cur_level > cur_limit;
    assign hit        = zc_strobe && over && (run_q == CNT_W'(STALL_HC - 1));
    assign stall_next = hit || (stall_q && !clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            stall_q <= 1'b0;
        end else begin
            stall_q <= stall_next;
            if (clr && !zc_strobe)  run_q <= '0;
            else if (zc_strobe) begin
                if (!over)                           run_q <= '0;
                else if (run_q != CNT_W'(STALL_HC))  run_q <= run_q + CNT_W'(1);
            end
        end
    end

    assert_run_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        run_q <= CNT_W'(STALL_HC));
    assert_under_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        (zc_strobe && !over) |=> (run_q == '0));
endmodule

// File: rtl/mdc_thermal_mon.sv
module mdc_thermal_mon #(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [TEMP_W-1:0] temp_level,
    input  logic [TEMP_W-1:0] temp_limit,
    output logic              therm_next,
    output logic              therm_q
);
    logic hot;

    assign hot        = temp_level > temp_limit;
    assign therm_next = hot || (therm_q && !clr);

    always_ff @(posedge clk) begin
        if (rst) therm_q <= 1'b0;
        else     therm_q <= therm_next;
    end

    assert_hot_latches_R5: assert property (@(posedge clk) disable iff (rst)
        hot |=> therm_q);
endmodule

// File: rtl/mixer_drive_ctrl.sv
module mixer_drive_ctrl
    import mdc_pkg::*;
#(
    parameter int CUR_W    = 10,
    parameter int TEMP_W   = 8,
    parameter int STALL_HC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zc_strobe,
    input  logic [1:0]        speed_sel,
    input  logic [CUR_W-1:0]  cur_level,
    input  logic [CUR_W-1:0]  cur_limit,
    input  logic [TEMP_W-1:0] temp_level,
    input  logic [TEMP_W-1:0] temp_limit,
    output logic              drive_out,
    output logic              led_power,
    output logic              led_overload,
    output logic              led_thermal
);
    speed_t sw_prev_q;
    logic   clr;
    logic   next_on;
    fault_t flt_next;
    fault_t flt_q;
    logic   drive_q;
    logic   pwr_q;

    assign clr = (speed_sel == speed_t'(0)) && (sw_prev_q != speed_t'(0));

    mdc_phase_sched u_sched (
        .clk       (clk),
        .rst       (rst),
        .zc_strobe (zc_strobe),
        .speed_sel (speed_sel),
        .next_on   (next_on)
    );

    mdc_stall_mon #(.CUR_W(CUR_W), .STALL_HC(STALL_HC)) u_stall (
        .clk        (clk),
        .rst        (rst),
        .zc_strobe  (zc_strobe),
        .clr        (clr),
        .cur_level  (cur_level),
        .cur_limit  (cur_limit),
        .stall_next (flt_next.stall),
        .stall_q    (flt_q.stall)
    );

    mdc_thermal_mon #(.TEMP_W(TEMP_W)) u_therm (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .temp_level (temp_level),
        .temp_limit (temp_limit),
        .therm_next (flt_next.thermal),
        .therm_q    (flt_q.thermal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_prev_q <= speed_t'(0);
            drive_q   <= 1'b0;
            pwr_q     <= 1'b0;
        end else begin
            sw_prev_q <= speed_sel;
            pwr_q     <= 1'b1;
            if (any_fault(flt_next)) drive_q <= 1'b0;
            else if (zc_strobe)      drive_q <= next_on;
        end
    end

    assign drive_out    = drive_q;
    assign led_power    = pwr_q;
    assign led_overload = flt_q.stall;
    assign led_thermal  = flt_q.thermal;

    assert_drive_rises_on_zc_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_out) |-> $past(zc_strobe));
    assert_stall_blocks_drive_R4: assert property (@(posedge clk) disable iff (rst)
        led_overload |-> !drive_out);
    assert_thermal_blocks_drive_R5: assert property (@(posedge clk) disable iff (rst)
        led_thermal |-> !drive_out);
    assert_switch_waits_for_zc_R6: assert property (@(posedge clk) disable iff (rst)
        !zc_strobe |=> !$rose(drive_out));
    assert_power_lamp_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> led_power);
endmodule

// File: tb/sim_mixer_drive_ctrl.sv
module sim_mixer_drive_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zc_strobe = 1'b0;
    logic [1:0] speed_sel = 2'd0;
    logic [9:0] cur_level = 10'd0;
    logic [9:0] cur_limit = 10'd500;
    logic [7:0] temp_level = 8'd0;
    logic [7:0] temp_limit = 8'd100;
    logic       drive_out, led_power, led_overload, led_thermal;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mixer_drive_ctrl u0 (
        .clk(clk), .rst(rst), .zc_strobe(zc_strobe), .speed_sel(speed_sel),
        .cur_level(cur_level), .cur_limit(cur_limit),
        .temp_level(temp_level), .temp_limit(temp_limit),
        .drive_out(drive_out), .led_power(led_power),
        .led_overload(led_overload), .led_thermal(led_thermal)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; zc_strobe = 1'b0;
        temp_level = 8'd0; cur_level = 10'd0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk); zc_strobe = 1'b1;
        @(negedge clk); zc_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R8 power low in reset", led_power, 1'b0);
        check("R2 drive low in reset", drive_out, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 power high after reset", led_power, 1'b1);
        check("R7 no overload after reset", led_overload, 1'b0);
        check("R7 no thermal after reset", led_thermal, 1'b0);
    endtask

    task automatic t_speeds();
        for (int n = 0; n < 4; n++) begin
            speed_sel = 2'(n);
            do_reset();
            idle(3);
            check("R2 no drive before first strobe", drive_out, 1'b0);
            for (int k = 0; k < 8; k++) begin
                strobe();
                check("R1 slot pattern", drive_out, ((k % 4) <= n) ? 1'b1 : 1'b0);
                idle(2);
                check("R1 held through half-cycle", drive_out, ((k % 4) <= n) ? 1'b1 : 1'b0);
            end
        end
    endtask

    task automatic t_midchange();
        speed_sel = 2'd0;
        do_reset();
        strobe();
        check("R1 slot0 on", drive_out, 1'b1);
        strobe();
        check("R1 slot1 off at speed 0", drive_out, 1'b0);
        speed_sel = 2'd3;
        idle(4);
        check("R6 no change mid half-cycle", drive_out, 1'b0);
        strobe();
        check("R6 new speed at next strobe", drive_out, 1'b1);
        speed_sel = 2'd1;
        idle(4);
        check("R6 still on until strobe", drive_out, 1'b1);
        strobe();
        check("R6 slot3 off at speed 1", drive_out, 1'b0);
    endtask

    task automatic t_stall();
        speed_sel = 2'd3;
        do_reset();
        cur_level = 10'd600;
        for (int k = 0; k < 5; k++) strobe();
        cur_level = 10'd500;
        strobe();
        check("R3 equal current is not over", led_overload, 1'b0);
        cur_level = 10'd600;
        for (int k = 0; k < 7; k++) strobe();
        check("R3 run restarted, 7 not enough", led_overload, 1'b0);
        check("R3 drive still on", drive_out, 1'b1);
        strobe();
        check("R4 overload on 8th", led_overload, 1'b1);
        check("R4 drive cut on stall", drive_out, 1'b0);
        cur_level = 10'd0;
        strobe();
        check("R7 stall latched", led_overload, 1'b1);
        check("R7 drive kept off", drive_out, 1'b0);
        @(negedge clk); speed_sel = 2'd1;
        strobe();
        check("R7 nonzero switch keeps fault", led_overload, 1'b1);
        @(negedge clk); speed_sel = 2'd0;
        @(negedge clk);
        check("R7 move to 0 clears overload", led_overload, 1'b0);
        check("R7 drive waits for strobe", drive_out, 1'b0);
    endtask

    task automatic t_thermal();
        speed_sel = 2'd3;
        do_reset();
        strobe();
        idle(2);
        temp_level = 8'd100;
        @(negedge clk);
        check("R5 equal temp no fault", led_thermal, 1'b0);
        check("R5 drive on at equal temp", drive_out, 1'b1);
        temp_level = 8'd101;
        @(negedge clk);
        check("R5 thermal set mid half-cycle", led_thermal, 1'b1);
        check("R5 drive cut", drive_out, 1'b0);
        temp_level = 8'd20;
        strobe();
        check("R7 thermal latched", led_thermal, 1'b1);
        check("R7 drive off after cool", drive_out, 1'b0);
        speed_sel = 2'd0;
        @(negedge clk);
        check("R7 clear by switch to 0", led_thermal, 1'b0);
        strobe();
        check("R7 drive resumes per slot", drive_out, 1'b0);
        speed_sel = 2'd3;
        do_reset();
        temp_level = 8'd200;
        @(negedge clk);
        @(negedge clk);
        speed_sel = 2'd0;
        @(negedge clk);
        check("R7 live fault wins over clear", led_thermal, 1'b1);
        do_reset();
        check("R7 reset clears thermal", led_thermal, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_speeds();
        t_midchange();
        t_stall();
        t_thermal();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule